// File: doc/BRIEF.md
# Stack Return Micro-Sequencer

This block runs the stack-unwinding steps of an 8-bit processor core for three one-byte instructions. The first is a return from interrupt, which restores the condition codes, accumulator, low index byte and program counter from the stack. The second is a return from subroutine, which restores only the program counter. The third resets the stack pointer, which forces the low byte of the stack pointer to all ones.

The block owns the 16-bit stack pointer and drives a synchronous byte-wide read port: a read issued in one cycle returns its byte on the read-data input in the next cycle. Each instruction follows a fixed cycle-by-cycle pattern of stack reads, one internal cycle and program-fetch cycles. The pattern is reported on a cycle-class output. Instruction prefetch belongs to the core around this block, so here the fetch cycles are only placeholder cycles with no memory traffic. A one-cycle start pulse carries the opcode. The block then reports busy until its final cycle, and pulses done in that final cycle. The core may also write the stack pointer directly while the block is idle.

Top module: `stack_return_seq`

## Requirements
- R1: After reset, busy, done and the read strobe are low, the cycle class is 0 (idle), the stack pointer holds 0x00FF, and the program counter, accumulator, index low byte and condition codes are all zero.
- R2: Every stack pull first adds one to the stack pointer, wrapping from 0xFFFF to 0x0000. It then reads the byte at the new value. The byte arrives on the read-data input one cycle after the read strobe.
- R3: Opcode 0x80 (return from interrupt) lasts 9 cycles. Its class codes are 1,1,1,1,1,2,3,3,3, where 1 is a stack read, 2 is internal and 3 is a fetch. It pulls, in order, the condition codes, the accumulator, the index low byte, the PC high byte and the PC low byte. It leaves the stack pointer 5 higher.
- R4: Opcode 0x81 (return from subroutine) lasts 5 cycles, with class codes 1,1,2,3,3. It pulls the PC high byte and then the PC low byte. It leaves the stack pointer 2 higher, and the condition codes, accumulator and index low byte unchanged.
- R5: Opcode 0x9C lasts 1 cycle with class code 3. It sets the stack pointer low byte to 0xFF, keeps the high byte, makes no read, and leaves every other register unchanged.
- R6: Any other opcode lasts 1 cycle with class code 2. It makes no read and changes no register, including the stack pointer.
- R7: A start pulse while busy is high is ignored, and that includes the cycle in which done is high.
- R8: Busy is high from the first cycle after an accepted start through the final cycle. Done is high only in that final cycle.
- R9: The program counter changes as one 16-bit value, at the end of the internal (class 2) cycle. It never changes in any other cycle.
- R10: A direct stack pointer write is applied at the next clock edge when the block is idle. It is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin the instruction in opcode_i |
| opcode_i | input | 8 | Opcode sampled with start_i |
| sp_load_i | input | 1 | Direct stack pointer write, honoured only when idle |
| sp_load_val_i | input | 16 | Value for the direct stack pointer write |
| mem_rd_o | output | 1 | Stack read strobe |
| mem_addr_o | output | 16 | Stack read address, zero when no read is made |
| mem_rdata_i | input | 8 | Byte returned one cycle after the strobe |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Final cycle of the sequence |
| cyc_kind_o | output | 2 | Cycle class: 0 idle, 1 stack read, 2 internal, 3 fetch |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter |
| ccr_o | output | 8 | Condition-code register |
| acc_o | output | 8 | Accumulator |
| xlo_o | output | 8 | Index register low byte |

## Verification
The hardest state to reach is a collision: a second start or a direct stack pointer write arriving while a long sequence is running, and above all a start in the very cycle where done is high. A single-cycle sequence would accept that start one cycle later. The bench reaches this state by running a return from interrupt in which it raises start with the stack-reset opcode in the third cycle and again in the done cycle, and requests a stack pointer write in the second cycle. It then checks that the nine-cycle pattern and the final registers are exactly those of an undisturbed run. Stack pointers at 0xFFFD and 0xFFFF push the pulls across the 16-bit wrap.

// File: rtl/srs_pkg.sv
package srs_pkg;

   typedef enum logic [1:0] {
      KIND_IDLE  = 2'd0,
      KIND_STACK = 2'd1,
      KIND_FREE  = 2'd2,
      KIND_FETCH = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      OP_RTI = 2'd0,
      OP_RTS = 2'd1,
      OP_RSP = 2'd2,
      OP_BAD = 2'd3
   } op_e;

   // slots in pull order of the longest sequence
   localparam int unsigned NUM_SLOTS = 5;
   localparam int unsigned SLOT_W    = 3;
   localparam int unsigned SLOT_PCH  = 3;
   localparam int unsigned SLOT_PCL  = 4;

   typedef struct packed {
      op_e        op;
      logic [2:0] npull;
      logic       nfree;
      logic [1:0] nfetch;
   } prof_t;

endpackage

// File: rtl/srs_decode.sv
module srs_decode
   import srs_pkg::*;
#(
   parameter int unsigned     DW        = 8,
   parameter logic [DW-1:0]   OPC_RTI   = 8'h80,
   parameter logic [DW-1:0]   OPC_RTS   = 8'h81,
   parameter logic [DW-1:0]   OPC_RSP   = 8'h9C,
   parameter int unsigned     RTI_FETCH = 3,
   parameter int unsigned     RTS_FETCH = 2
) (
   input  logic [DW-1:0] opcode_i,
   output prof_t         prof_o
);

   if (RTI_FETCH > 3 || RTS_FETCH > 3) begin : g_bad_fetch
      $error("srs_decode: fetch counts must fit in two bits");
   end
   if (OPC_RTI == OPC_RTS || OPC_RTI == OPC_RSP || OPC_RTS == OPC_RSP) begin : g_bad_opc
      $error("srs_decode: opcodes must be distinct");
   end

   localparam logic [1:0] RTI_F = RTI_FETCH[1:0];
   localparam logic [1:0] RTS_F = RTS_FETCH[1:0];

   always_comb begin
      prof_o = '{op: OP_BAD, npull: 3'd0, nfree: 1'b1, nfetch: 2'd0};
      if (opcode_i == OPC_RTI) begin
         prof_o = '{op: OP_RTI, npull: 3'(NUM_SLOTS), nfree: 1'b1, nfetch: RTI_F};
      end else if (opcode_i == OPC_RTS) begin
         prof_o = '{op: OP_RTS, npull: 3'(NUM_SLOTS - SLOT_PCH), nfree: 1'b1, nfetch: RTS_F};
      end else if (opcode_i == OPC_RSP) begin
         prof_o = '{op: OP_RSP, npull: 3'd0, nfree: 1'b0, nfetch: 2'd1};
      end
   end

endmodule

// File: rtl/srs_seq.sv
module srs_seq
   import srs_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  prof_t             prof_i,
   output logic              busy_o,
   output logic              done_o,
   output kind_e             kind_o,
   output logic              rd_o,
   output logic              cap_o,
   output logic [SLOT_W-1:0] cap_slot_o,
   output logic              rsp_o
);

   localparam int unsigned MAX_LEN = NUM_SLOTS + 1 + 3;

   if ((2 ** CNT_W) <= MAX_LEN) begin : g_bad_cnt
      $error("srs_seq: CNT_W too narrow for the longest sequence");
   end

   logic             busy_q;
   prof_t            prof_q;
   logic [CNT_W-1:0] cyc_q;
   logic [CNT_W-1:0] n_pull, n_free, total, slot_w;
   logic             last;

   assign n_pull = CNT_W'(prof_q.npull);
   assign n_free = CNT_W'(prof_q.nfree);
   assign total  = n_pull + n_free + CNT_W'(prof_q.nfetch);
   assign last   = busy_q && (cyc_q == total);

   always_comb begin
      if (!busy_q)                     kind_o = KIND_IDLE;
      else if (cyc_q <= n_pull)        kind_o = KIND_STACK;
      else if (cyc_q <= n_pull + n_free) kind_o = KIND_FREE;
      else                             kind_o = KIND_FETCH;
   end

   // a byte read in cycle k is captured in cycle k+1
   assign slot_w     = cyc_q + CNT_W'(NUM_SLOTS - 2) - n_pull;
   assign cap_o      = busy_q && (cyc_q >= CNT_W'(2)) && (cyc_q <= n_pull + CNT_W'(1));
   assign cap_slot_o = slot_w[SLOT_W-1:0];
   assign rd_o       = (kind_o == KIND_STACK);
   assign rsp_o      = busy_q && (prof_q.op == OP_RSP);
   assign busy_o     = busy_q;
   assign done_o     = last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         prof_q <= '{op: OP_BAD, npull: 3'd0, nfree: 1'b0, nfetch: 2'd0};
         cyc_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            prof_q <= prof_i;
            cyc_q  <= CNT_W'(1);
         end
      end else if (last) begin
         busy_q <= 1'b0;
         cyc_q  <= '0;
      end else begin
         cyc_q  <= cyc_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/srs_sp_unit.sv
module srs_sp_unit #(
   parameter int unsigned   AW     = 16,
   parameter int unsigned   DW     = 8,
   parameter logic [AW-1:0] SP_RST = 16'h00FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_i,
   input  logic          rsp_i,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   output logic [AW-1:0] sp_o,
   output logic [AW-1:0] next_addr_o
);

   if (AW <= DW) begin : g_bad_w
      $error("srs_sp_unit: stack pointer must be wider than one byte");
   end

   logic [AW-1:0] sp_q;
   logic [AW-1:0] sp_inc;

   assign sp_inc      = sp_q + AW'(1);
   assign next_addr_o = sp_inc;
   assign sp_o        = sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sp_q <= SP_RST;
      else if (inc_i)  sp_q <= sp_inc;
      else if (rsp_i)  sp_q <= {sp_q[AW-1:DW], {DW{1'b1}}};
      else if (load_i) sp_q <= load_val_i;
   end

endmodule

// File: rtl/srs_regs.sv
module srs_regs
   import srs_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 8,
   parameter bit          ATOMIC_PC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [DW-1:0]     rdata_i,
   output logic [DW-1:0]     ccr_o,
   output logic [DW-1:0]     acc_o,
   output logic [DW-1:0]     xlo_o,
   output logic [AW-1:0]     pc_o
);

   localparam int unsigned NBYTE = SLOT_PCH;

   if (AW != 2 * DW) begin : g_bad_pc
      $error("srs_regs: program counter must be two bytes wide");
   end

   logic [DW-1:0] byte_q [NBYTE];
   logic [AW-1:0] pc_q;

   for (genvar g = 0; g < NBYTE; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) byte_q[g] <= '0;
         else if (cap_i && slot_i == SLOT_W'(g)) byte_q[g] <= rdata_i;
      end
   end

   if (ATOMIC_PC) begin : g_pc_staged
      logic [DW-1:0] pch_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pch_q <= '0;
            pc_q  <= '0;
         end else if (cap_i) begin
            if (slot_i == SLOT_W'(SLOT_PCH)) pch_q <= rdata_i;
            if (slot_i == SLOT_W'(SLOT_PCL)) pc_q  <= {pch_q, rdata_i};
         end
      end
   end else begin : g_pc_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_q <= '0;
         end else if (cap_i) begin
            if (slot_i == SLOT_W'(SLOT_PCH)) pc_q[AW-1:DW] <= rdata_i;
            if (slot_i == SLOT_W'(SLOT_PCL)) pc_q[DW-1:0]  <= rdata_i;
         end
      end
   end

   assign ccr_o = byte_q[0];
   assign acc_o = byte_q[1];
   assign xlo_o = byte_q[2];
   assign pc_o  = pc_q;

endmodule

// File: rtl/stack_return_seq.sv
module stack_return_seq
   import srs_pkg::*;
#(
   parameter int unsigned   AW        = 16,
   parameter int unsigned   DW        = 8,
   parameter logic [AW-1:0] SP_RST    = 16'h00FF,
   parameter logic [DW-1:0] OPC_RTI   = 8'h80,
   parameter logic [DW-1:0] OPC_RTS   = 8'h81,
   parameter logic [DW-1:0] OPC_RSP   = 8'h9C,
   parameter int unsigned   RTI_FETCH = 3,
   parameter int unsigned   RTS_FETCH = 2,
   parameter int unsigned   CNT_W     = 4,
   parameter bit            ATOMIC_PC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] opcode_i,
   input  logic          sp_load_i,
   input  logic [AW-1:0] sp_load_val_i,
   output logic          mem_rd_o,
   output logic [AW-1:0] mem_addr_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [1:0]    cyc_kind_o,
   output logic [AW-1:0] sp_o,
   output logic [AW-1:0] pc_o,
   output logic [DW-1:0] ccr_o,
   output logic [DW-1:0] acc_o,
   output logic [DW-1:0] xlo_o
);

   prof_t             prof;
   kind_e             kind;
   logic              rd, cap, rsp, busy;
   logic [SLOT_W-1:0] cap_slot;
   logic [AW-1:0]     next_addr;

   srs_decode #(
      .DW(DW), .OPC_RTI(OPC_RTI), .OPC_RTS(OPC_RTS), .OPC_RSP(OPC_RSP),
      .RTI_FETCH(RTI_FETCH), .RTS_FETCH(RTS_FETCH)
   ) u_dec (
      .opcode_i (opcode_i),
      .prof_o   (prof)
   );

   srs_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .prof_i     (prof),
      .busy_o     (busy),
      .done_o     (done_o),
      .kind_o     (kind),
      .rd_o       (rd),
      .cap_o      (cap),
      .cap_slot_o (cap_slot),
      .rsp_o      (rsp)
   );

   srs_sp_unit #(.AW(AW), .DW(DW), .SP_RST(SP_RST)) u_sp (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_i       (rd),
      .rsp_i       (rsp),
      .load_i      (sp_load_i && !busy),
      .load_val_i  (sp_load_val_i),
      .sp_o        (sp_o),
      .next_addr_o (next_addr)
   );

   srs_regs #(.AW(AW), .DW(DW), .ATOMIC_PC(ATOMIC_PC)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap),
      .slot_i  (cap_slot),
      .rdata_i (mem_rdata_i),
      .ccr_o   (ccr_o),
      .acc_o   (acc_o),
      .xlo_o   (xlo_o),
      .pc_o    (pc_o)
   );

   assign busy_o     = busy;
   assign mem_rd_o   = rd;
   assign mem_addr_o = rd ? next_addr : '0;
   assign cyc_kind_o = kind;

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
   parameter int unsigned AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sp_load_i,
   input logic          busy_o,
   input logic          done_o,
   input logic [1:0]    cyc_kind_o,
   input logic          mem_rd_o,
   input logic [AW-1:0] mem_addr_o,
   input logic [AW-1:0] sp_o,
   input logic [AW-1:0] pc_o
);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o); // R8
   AST_SP_PREINC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |=> (sp_o == $past(mem_addr_o))); // R2
   AST_READ_IN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> (busy_o && cyc_kind_o == 2'd1)); // R3
   AST_PC_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && cyc_kind_o == 2'd2) |=> $stable(pc_o)); // R9
   AST_IDLE_SP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !sp_load_i) |=> $stable(sp_o)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cyc_kind_o == 2'd0 && !mem_rd_o)); // R1

endmodule

bind stack_return_seq srs_checker #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sp_load_i  (sp_load_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .cyc_kind_o (cyc_kind_o),
   .mem_rd_o   (mem_rd_o),
   .mem_addr_o (mem_addr_o),
   .sp_o       (sp_o),
   .pc_o       (pc_o)
);

// File: tb/stack_return_seq_test.sv
`timescale 1ns/1ps
module stack_return_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  opcode_i = 8'h00;
   logic        sp_load_i = 1'b0;
   logic [15:0] sp_load_val_i = 16'h0000;
   logic        mem_rd_o;
   logic [15:0] mem_addr_o;
   logic [7:0]  mem_rdata_i = 8'h00;
   logic        busy_o, done_o;
   logic [1:0]  cyc_kind_o;
   logic [15:0] sp_o, pc_o;
   logic [7:0]  ccr_o, acc_o, xlo_o;

   int n_vec = 0;
   int n_bad = 0;
   int n_clk = 0;

   logic [15:0] m_sp, m_pc;
   logic [7:0]  m_ccr, m_a, m_x;

   always #4 clk = ~clk;

   stack_return_seq uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
      .sp_load_i(sp_load_i), .sp_load_val_i(sp_load_val_i),
      .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
      .busy_o(busy_o), .done_o(done_o), .cyc_kind_o(cyc_kind_o),
      .sp_o(sp_o), .pc_o(pc_o), .ccr_o(ccr_o), .acc_o(acc_o), .xlo_o(xlo_o)
   );

   function automatic logic [7:0] stack_byte(input logic [15:0] a);
      return a[7:0] + (a[15:8] ^ 8'h96);
   endfunction

   // synchronous memory: data one cycle after the strobe
   always_ff @(posedge clk) begin
      if (mem_rd_o) mem_rdata_i <= stack_byte(mem_addr_o);
   end

   always @(posedge clk) begin
      n_clk++;
      if (n_clk > 100000) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", n_clk);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_len(input logic [7:0] op);
      case (op)
         8'h80:   return 9;
         8'h81:   return 5;
         default: return 1;
      endcase
   endfunction

   function automatic logic [1:0] exp_kind(input logic [7:0] op, input int c);
      case (op)
         8'h80:   return (c <= 5) ? 2'd1 : (c == 6) ? 2'd2 : 2'd3;
         8'h81:   return (c <= 2) ? 2'd1 : (c == 3) ? 2'd2 : 2'd3;
         8'h9C:   return 2'd3;
         default: return 2'd2;
      endcase
   endfunction

   function automatic int exp_pulls(input logic [7:0] op);
      return (op == 8'h80) ? 5 : (op == 8'h81) ? 2 : 0;
   endfunction

   task automatic load_sp(input logic [15:0] v);
      @(negedge clk);
      sp_load_i = 1'b1;
      sp_load_val_i = v;
      @(negedge clk);
      sp_load_i = 1'b0;
      m_sp = v;
      check("R10", "idle sp write", 32'(sp_o), 32'(v));
   endtask

   // poke: collide with start and sp writes during the run (R7, R10)
   task automatic run_op(input logic [7:0] op, input bit poke);
      int          n;
      int          np;
      logic [15:0] s;
      logic [15:0] pc0;
      n   = exp_len(op);
      np  = exp_pulls(op);
      s   = m_sp;
      pc0 = m_pc;
      @(negedge clk);
      start_i  = 1'b1;
      opcode_i = op;
      for (int c = 1; c <= n; c++) begin
         @(negedge clk);
         start_i   = 1'b0;
         sp_load_i = 1'b0;
         check((op == 8'h80) ? "R3" : (op == 8'h81) ? "R4" : (op == 8'h9C) ? "R5" : "R6",
               $sformatf("kind op %0h cyc %0d", op, c), 32'(cyc_kind_o), 32'(exp_kind(op, c)));
         check("R8", $sformatf("busy op %0h cyc %0d", op, c), 32'(busy_o), 32'd1);
         check("R8", $sformatf("done op %0h cyc %0d", op, c), 32'(done_o), 32'(c == n));
         check("R2", $sformatf("read addr op %0h cyc %0d", op, c),
               {15'd0, mem_rd_o, mem_addr_o},
               (c <= np) ? {16'h0001, 16'(s + 16'(c))} : 32'd0);
         if (c <= np + 1)
            check("R9", $sformatf("pc held op %0h cyc %0d", op, c), 32'(pc_o), 32'(pc0));
         if (poke && c == 2) begin
            sp_load_i = 1'b1;
            sp_load_val_i = 16'h7777;
         end
         if (poke && (c == 3 || c == n)) begin
            start_i  = 1'b1;
            opcode_i = 8'h9C;
         end
      end
      case (op)
         8'h80: begin
            m_ccr = stack_byte(s + 16'd1);
            m_a   = stack_byte(s + 16'd2);
            m_x   = stack_byte(s + 16'd3);
            m_pc  = {stack_byte(s + 16'd4), stack_byte(s + 16'd5)};
            m_sp  = s + 16'd5;
         end
         8'h81: begin
            m_pc = {stack_byte(s + 16'd1), stack_byte(s + 16'd2)};
            m_sp = s + 16'd2;
         end
         8'h9C: m_sp = {s[15:8], 8'hFF};
         default: ;
      endcase
      @(negedge clk);
      start_i = 1'b0;
      check("R8", "busy after done", 32'(busy_o), 32'd0);
      check("R2", "final sp", 32'(sp_o), 32'(m_sp));
      check("R3", "ccr", 32'(ccr_o), 32'(m_ccr));
      check("R3", "acc", 32'(acc_o), 32'(m_a));
      check("R3", "xlo", 32'(xlo_o), 32'(m_x));
      check("R9", "pc", 32'(pc_o), 32'(m_pc));
      if (poke) begin
         @(negedge clk);
         check("R7", "start in done cycle ignored", 32'(busy_o), 32'd0);
         check("R10", "sp write while busy ignored", 32'(sp_o), 32'(m_sp));
      end
   endtask

   // {opcode, starting sp, expected length}
   localparam logic [27:0] VEC [9] = '{
      {8'h80, 16'h0100, 4'd9},
      {8'h81, 16'h01F0, 4'd5},
      {8'h9C, 16'h1234, 4'd1},
      {8'h00, 16'h0200, 4'd1},
      {8'h80, 16'hFFFD, 4'd9},
      {8'h81, 16'hFFFF, 4'd5},
      {8'h82, 16'h3456, 4'd1},
      {8'h9C, 16'hABFF, 4'd1},
      {8'h80, 16'h4000, 4'd9}
   };

   initial begin
      m_sp = 16'h00FF; m_pc = '0; m_ccr = '0; m_a = '0; m_x = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "busy", 32'(busy_o), 32'd0);
      check("R1", "done", 32'(done_o), 32'd0);
      check("R1", "read", 32'(mem_rd_o), 32'd0);
      check("R1", "kind", 32'(cyc_kind_o), 32'd0);
      check("R1", "sp", 32'(sp_o), 32'h00FF);
      check("R1", "regs", {pc_o, ccr_o, acc_o | xlo_o}, 32'd0);

      for (int i = 0; i < 9; i++) begin
         load_sp(VEC[i][19:4]);
         check("R8", $sformatf("length vec %0d", i),
               32'(exp_len(VEC[i][27:20])), 32'(VEC[i][3:0]));
         run_op(VEC[i][27:20], 1'b0);
      end

      // collisions during a long run: R7 and R10
      load_sp(16'h0300);
      run_op(8'h80, 1'b1);
      // back-to-back after a collision run: R4 unaffected registers
      run_op(8'h81, 1'b0);
      // R6 unknown opcode straight after R5
      run_op(8'h9C, 1'b0);
      run_op(8'hFF, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule